// File: doc/BRIEF.md
# Performance-Linked Cache Bank Power Controller

This block decides, once per monitoring epoch, which banks of a shared multi-bank last-level cache stay powered. It counts per-bank access strobes during each epoch. At the epoch boundary it receives the epoch's retired-instruction and cycle totals and compares the resulting IPC against a baseline captured in the first epoch after reset. From that comparison, and from the selected policy, it powers one bank down or one bank back up.

When a bank is powered down, the cache controller redirects that bank's requests through a per-bank remap table to an active target bank. When a bank is powered back up, the block raises a migration request. The controller then moves the displaced lines home and acknowledges. Only after that acknowledge does the remap entry revert to the bank itself. Four policies can be selected at run time. The first stops shrinking permanently. The second resizes freely. The third stops shrinking for good but still restarts banks. The fourth resizes freely but waits a cool-down period after every change.

Top module: `cache_bank_pwr_ctrl`

## Requirements
- R1: After reset all banks are powered, every remap entry holds its own bank index and no migration request is raised.
- R2: The first epoch boundary after reset only records the baseline instruction and cycle totals; power state and remap table stay unchanged.
- R3: An epoch counts as degraded when base_inst*cyc >= inst*base_cyc and (base_inst*cyc - inst*base_cyc)*100 >= thresh_pct*base_inst*cyc. This is the same as (baseline IPC - IPC)*100 >= thresh_pct * baseline IPC, and equality counts as degraded.
- R4: The bank chosen for shutdown is the powered bank with the fewest accesses in the epoch, the lowest index winning ties. No shutdown happens if only one bank is powered.
- R5: On shutdown, the target is the powered bank with the fewest accesses other than the victim, the lowest index winning ties. Every remap entry that pointed at the victim, including the victim's own entry, is rewritten to the target. A powered bank whose migration is complete maps to itself.
- R6: At most one bank changes power state per epoch. The access counts are cleared at every epoch boundary; a strobe in the boundary cycle is not counted.
- R7: mode_i = 0 (stop-on-loss): a non-degraded epoch shuts a bank down. The first degraded epoch stops all further shutdown until reset. No bank is ever restarted in this mode.
- R8: mode_i = 1 (free resize): a degraded epoch restarts the lowest-index powered-off bank, if there is one. Otherwise a non-degraded epoch shuts a bank down.
- R9: mode_i = 2 (shrink-once): acts as mode 1, but the first degraded epoch stops shutdown until reset, while restarts remain allowed.
- R10: mode_i = 3 (damped resize): acts as mode 1, but after any resize no resize happens for the next COOL_EPOCHS evaluated epochs (default 2).
- R11: A restart raises migrate_req_o with migrate_bank_o set to the restarted bank. It holds until migrate_ack_i, keeps the bank's remap entry on its old target until then, and blocks any resize while pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy select (0 stop-on-loss, 1 free, 2 shrink-once, 3 damped) |
| thresh_pct_i | input | PCT_W | Allowed IPC loss in percent |
| bank_access_i | input | NUM_BANKS | Per-bank access strobe, one per cycle |
| epoch_end_i | input | 1 | Epoch boundary pulse; totals valid in this cycle |
| inst_cnt_i | input | INST_W | Instructions retired in the epoch |
| cyc_cnt_i | input | CYC_W | Cycles in the epoch |
| migrate_ack_i | input | 1 | Migration back to the restarted bank finished |
| bank_pwr_o | output | NUM_BANKS | Per-bank power enable |
| remap_tgt_o | output | NUM_BANKS*IDX_W | Per-bank redirect target, bank i at bits [i*IDX_W +: IDX_W] |
| migrate_req_o | output | 1 | Migration back to a restarted bank requested |
| migrate_bank_o | output | IDX_W | Bank being restarted |

## Verification
Several properties are checked on every cycle. At least one bank stays powered. No more than one power bit flips per cycle. Every powered-off bank redirects to a powered bank, and completed banks map to themselves. A migration request holds until it is acknowledged, and mode 0 never powers a bank up. The usage counters clear at boundaries and saturate. Which bank is picked, the exact IPC threshold boundary, the sticky stop of modes 0 and 2, the cool-down count of mode 3 and the blocking of resizes during migration show only in the bench's epoch sequences.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef enum logic [1:0] {
    MODE_STOP   = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_ONCE   = 2'd2,
    MODE_DAMPED = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/cbp_usage_ctr.sv
module cbp_usage_ctr #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_BANKS-1:0]            access_i,
  input  logic                            clear_i,
  output logic [NUM_BANKS-1:0][CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ctr
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           cnt_q <= '0;
      else if (clear_i)                      cnt_q <= '0;
      else if (access_i[g] && cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[g] = cnt_q;

    // R6
    epoch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (cnt_q == '0));
    // R6
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '1 && !clear_i) |=> (cnt_q == '1));
  end
endmodule

// File: rtl/cbp_ipc_cmp.sv
module cbp_ipc_cmp #(
  parameter int INST_W = 16,
  parameter int CYC_W  = 16,
  parameter int PCT_W  = 7
) (
  input  logic [INST_W-1:0] base_inst_i,
  input  logic [CYC_W-1:0]  base_cyc_i,
  input  logic [INST_W-1:0] inst_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [PCT_W-1:0]  thresh_i,
  output logic              degraded_o
);
  localparam int PROD_W = INST_W + CYC_W;
  localparam int WIDE_W = PROD_W + PCT_W + 7;

  logic [PROD_W-1:0] base_x, cur_x, loss;
  logic [WIDE_W-1:0] lhs, rhs;

  // cross-multiplied IPCs avoid any divider
  assign base_x = PROD_W'(base_inst_i) * PROD_W'(cyc_i);
  assign cur_x  = PROD_W'(inst_i) * PROD_W'(base_cyc_i);
  assign loss   = base_x - cur_x;
  assign lhs    = WIDE_W'(loss) * WIDE_W'(7'd100);
  assign rhs    = WIDE_W'(thresh_i) * WIDE_W'(base_x);
  assign degraded_o = (base_x >= cur_x) && (lhs >= rhs);
endmodule

// File: rtl/cbp_bank_pick.sv
module cbp_bank_pick #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 12,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] cnt_i,
  input  logic [NUM_BANKS-1:0]            pwr_i,
  output logic [IDX_W-1:0]                victim_o,
  output logic [IDX_W-1:0]                target_o,
  output logic                            can_shut_o,
  output logic [IDX_W-1:0]                low_off_o,
  output logic                            any_off_o
);
  logic [CNT_W-1:0] vic_cnt, tgt_cnt;
  logic             vic_ok, tgt_ok;

  always_comb begin
    victim_o = '0;
    vic_cnt  = '0;
    vic_ok   = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (pwr_i[i] && (!vic_ok || cnt_i[i] < vic_cnt)) begin
        victim_o = IDX_W'(i);
        vic_cnt  = cnt_i[i];
        vic_ok   = 1'b1;
      end
    end
  end

  always_comb begin
    target_o = '0;
    tgt_cnt  = '0;
    tgt_ok   = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (pwr_i[i] && IDX_W'(i) != victim_o && (!tgt_ok || cnt_i[i] < tgt_cnt)) begin
        target_o = IDX_W'(i);
        tgt_cnt  = cnt_i[i];
        tgt_ok   = 1'b1;
      end
    end
  end

  assign can_shut_o = vic_ok && tgt_ok;

  always_comb begin
    low_off_o = '0;
    any_off_o = 1'b0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (!pwr_i[i]) begin
        low_off_o = IDX_W'(i);
        any_off_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cache_bank_pwr_ctrl.sv
module cache_bank_pwr_ctrl
  import cbp_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int CNT_W       = 12,
  parameter int INST_W      = 16,
  parameter int CYC_W       = 16,
  parameter int PCT_W       = 7,
  parameter int COOL_EPOCHS = 2,
  localparam int IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int COOL_W     = $clog2(COOL_EPOCHS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 mode_i,
  input  logic [PCT_W-1:0]           thresh_pct_i,
  input  logic [NUM_BANKS-1:0]       bank_access_i,
  input  logic                       epoch_end_i,
  input  logic [INST_W-1:0]          inst_cnt_i,
  input  logic [CYC_W-1:0]           cyc_cnt_i,
  input  logic                       migrate_ack_i,
  output logic [NUM_BANKS-1:0]       bank_pwr_o,
  output logic [NUM_BANKS*IDX_W-1:0] remap_tgt_o,
  output logic                       migrate_req_o,
  output logic [IDX_W-1:0]           migrate_bank_o
);
  pwr_mode_e mode;
  assign mode = pwr_mode_e'(mode_i);

  logic [NUM_BANKS-1:0][CNT_W-1:0] acc_cnt;
  logic [NUM_BANKS-1:0][IDX_W-1:0] remap_q, remap_d;
  logic [NUM_BANKS-1:0]            pwr_q, pwr_d;
  logic                            base_ok_q;
  logic [INST_W-1:0]               base_inst_q;
  logic [CYC_W-1:0]                base_cyc_q;
  logic                            stop_q, stop_d;
  logic [COOL_W-1:0]               cool_q, cool_d;
  logic                            mig_q, mig_d;
  logic [IDX_W-1:0]                mig_bank_q, mig_bank_d;

  logic             degraded, can_shut, any_off, eval, may_resize, sticky_mode;
  logic             do_up, do_down;
  logic [IDX_W-1:0] victim, target, low_off;

  cbp_usage_ctr #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_usage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .access_i (bank_access_i),
    .clear_i  (epoch_end_i),
    .cnt_o    (acc_cnt)
  );

  cbp_ipc_cmp #(.INST_W(INST_W), .CYC_W(CYC_W), .PCT_W(PCT_W)) u_cmp (
    .base_inst_i (base_inst_q),
    .base_cyc_i  (base_cyc_q),
    .inst_i      (inst_cnt_i),
    .cyc_i       (cyc_cnt_i),
    .thresh_i    (thresh_pct_i),
    .degraded_o  (degraded)
  );

  cbp_bank_pick #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_pick (
    .cnt_i      (acc_cnt),
    .pwr_i      (pwr_q),
    .victim_o   (victim),
    .target_o   (target),
    .can_shut_o (can_shut),
    .low_off_o  (low_off),
    .any_off_o  (any_off)
  );

  assign eval        = epoch_end_i && base_ok_q;
  assign sticky_mode = (mode == MODE_STOP) || (mode == MODE_ONCE);
  assign may_resize  = !mig_q && !(mode == MODE_DAMPED && cool_q != '0);
  assign do_up       = eval && may_resize && degraded && any_off && (mode != MODE_STOP);
  assign do_down     = eval && may_resize && !degraded && can_shut && !(sticky_mode && stop_q);

  always_comb begin
    pwr_d      = pwr_q;
    remap_d    = remap_q;
    stop_d     = stop_q;
    cool_d     = cool_q;
    mig_d      = mig_q;
    mig_bank_d = mig_bank_q;

    if (eval && degraded && sticky_mode) stop_d = 1'b1;

    if (do_up || do_down)            cool_d = COOL_W'(COOL_EPOCHS);
    else if (eval && cool_q != '0)   cool_d = cool_q - 1'b1;

    if (mig_q && migrate_ack_i) begin
      mig_d               = 1'b0;
      remap_d[mig_bank_q] = mig_bank_q;
    end

    if (do_down) begin
      pwr_d[victim] = 1'b0;
      for (int i = 0; i < NUM_BANKS; i++)
        if (remap_q[i] == victim) remap_d[i] = target;
    end else if (do_up) begin
      // remap entry stays on its target until migration is acknowledged
      pwr_d[low_off] = 1'b1;
      mig_d          = 1'b1;
      mig_bank_d     = low_off;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_ok_q   <= 1'b0;
      base_inst_q <= '0;
      base_cyc_q  <= '0;
      pwr_q       <= '1;
      stop_q      <= 1'b0;
      cool_q      <= '0;
      mig_q       <= 1'b0;
      mig_bank_q  <= '0;
      for (int i = 0; i < NUM_BANKS; i++) remap_q[i] <= IDX_W'(i);
    end else begin
      if (epoch_end_i && !base_ok_q) begin
        base_ok_q   <= 1'b1;
        base_inst_q <= inst_cnt_i;
        base_cyc_q  <= cyc_cnt_i;
      end
      pwr_q      <= pwr_d;
      remap_q    <= remap_d;
      stop_q     <= stop_d;
      cool_q     <= cool_d;
      mig_q      <= mig_d;
      mig_bank_q <= mig_bank_d;
    end
  end

  assign bank_pwr_o     = pwr_q;
  assign migrate_req_o  = mig_q;
  assign migrate_bank_o = mig_bank_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_out
    assign remap_tgt_o[g*IDX_W +: IDX_W] = remap_q[g];

    // R5
    self_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_q[g] && !(mig_q && mig_bank_q == IDX_W'(g))) |-> (remap_q[g] == IDX_W'(g)));
    // R5
    live_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_q[g] |-> pwr_q[remap_q[g]]);
  end

  // R4
  one_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q != '0);
  // R6
  single_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pwr_q ^ $past(pwr_q)) <= 1);
  // R11
  mig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mig_q && !migrate_ack_i) |=> (mig_q && $stable(mig_bank_q)));
  // R11
  mig_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mig_q |=> $stable(pwr_q));
  // R7
  stop_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_STOP) |=> ((pwr_q & ~$past(pwr_q)) == '0));
endmodule

// File: tb/cache_bank_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module cache_bank_pwr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [1:0]  mode_i;
  logic [6:0]  thresh_pct_i;
  logic [3:0]  bank_access_i;
  logic        epoch_end_i;
  logic [15:0] inst_cnt_i, cyc_cnt_i;
  logic        migrate_ack_i;
  logic [3:0]  bank_pwr_o;
  logic [7:0]  remap_tgt_o;
  logic        migrate_req_o;
  logic [1:0]  migrate_bank_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cache_bank_pwr_ctrl dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .mode_i         (mode_i),
    .thresh_pct_i   (thresh_pct_i),
    .bank_access_i  (bank_access_i),
    .epoch_end_i    (epoch_end_i),
    .inst_cnt_i     (inst_cnt_i),
    .cyc_cnt_i      (cyc_cnt_i),
    .migrate_ack_i  (migrate_ack_i),
    .bank_pwr_o     (bank_pwr_o),
    .remap_tgt_o    (remap_tgt_o),
    .migrate_req_o  (migrate_req_o),
    .migrate_bank_o (migrate_bank_o)
  );

  // acc: one nibble per bank, bank3 high; remap: 2 bits per bank, bank3 high
  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] acc;
    logic [15:0] inst;
    logic [3:0]  pwr;
    logic [7:0]  remap;
    logic        mig;
    logic [1:0]  mbank;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 16'h5555, 16'd800, 4'b1111, 8'b11_10_01_00, 1'b0, 2'd0}, // R2 baseline
    '{2'd1, 16'h2413, 16'd790, 4'b1101, 8'b11_10_11_00, 1'b0, 2'd0}, // R4 R5 R8
    '{2'd1, 16'h5203, 16'd790, 4'b1001, 8'b11_00_11_00, 1'b0, 2'd0}, // R6 fresh counts
    '{2'd1, 16'h6001, 16'd780, 4'b1000, 8'b11_11_11_11, 1'b0, 2'd0}, // R5 chained remap
    '{2'd1, 16'h9000, 16'd790, 4'b1000, 8'b11_11_11_11, 1'b0, 2'd0}, // R4 last bank kept
    '{2'd1, 16'h0000, 16'd600, 4'b1001, 8'b11_11_11_11, 1'b1, 2'd0}, // R8 restart
    '{2'd1, 16'h0000, 16'd600, 4'b1011, 8'b11_11_11_00, 1'b1, 2'd1}, // R8 restart
    '{2'd3, 16'h1052, 16'd790, 4'b1011, 8'b11_11_01_00, 1'b0, 2'd0}, // R10 cool 2
    '{2'd3, 16'h1052, 16'd790, 4'b1011, 8'b11_11_01_00, 1'b0, 2'd0}, // R10 cool 1
    '{2'd3, 16'h1052, 16'd790, 4'b0011, 8'b00_00_01_00, 1'b0, 2'd0}, // R10 resumes
    '{2'd3, 16'h0000, 16'd600, 4'b0011, 8'b00_00_01_00, 1'b0, 2'd0}, // R10 blocks up
    '{2'd2, 16'h0000, 16'd600, 4'b0111, 8'b00_00_01_00, 1'b1, 2'd2}, // R9 restart, stop
    '{2'd2, 16'h9111, 16'd790, 4'b0111, 8'b00_10_01_00, 1'b0, 2'd0}, // R9 no shutdown
    '{2'd2, 16'h0000, 16'd600, 4'b1111, 8'b00_10_01_00, 1'b1, 2'd3}  // R9 restart
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_epoch(input logic [1:0] m, input logic [15:0] acc, input logic [15:0] inst);
    mode_i = m;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      for (int b = 0; b < 4; b++) bank_access_i[b] = (acc[4*b +: 4] > 4'(k));
    end
    @(negedge clk);
    bank_access_i = '0;
    epoch_end_i   = 1'b1;
    inst_cnt_i    = inst;
    cyc_cnt_i     = 16'd1000;
    @(negedge clk);
    epoch_end_i   = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    migrate_ack_i = 1'b1;
    @(negedge clk);
    migrate_ack_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    mode_i = 2'd1; thresh_pct_i = 7'd10; bank_access_i = '0; epoch_end_i = 1'b0;
    inst_cnt_i = '0; cyc_cnt_i = '0; migrate_ack_i = 1'b0;
    do_reset();

    check("R1", "pwr", 32'(bank_pwr_o), 32'hF);
    check("R1", "remap", 32'(remap_tgt_o), 32'hE4);
    check("R1", "mig", 32'(migrate_req_o), 32'd0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      run_epoch(t.mode, t.acc, t.inst);
      check("R6", $sformatf("v%0d pwr", v), 32'(bank_pwr_o), 32'(t.pwr));
      check("R5", $sformatf("v%0d remap", v), 32'(remap_tgt_o), 32'(t.remap));
      check("R11", $sformatf("v%0d mig", v), 32'(migrate_req_o), 32'(t.mig));
      if (t.mig) begin
        logic [7:0] rm;
        check("R11", $sformatf("v%0d mbank", v), 32'(migrate_bank_o), 32'(t.mbank));
        pulse_ack();
        rm = t.remap;
        rm[2*t.mbank +: 2] = t.mbank;
        check("R11", $sformatf("v%0d mig after ack", v), 32'(migrate_req_o), 32'd0);
        check("R11", $sformatf("v%0d remap after ack", v), 32'(remap_tgt_o), 32'(rm));
      end
    end

    // R3 threshold boundary, R4 tie to lowest index, R11 blocking while pending
    do_reset();
    run_epoch(2'd1, 16'h0000, 16'd800);
    check("R2", "baseline pwr", 32'(bank_pwr_o), 32'hF);
    run_epoch(2'd1, 16'h0000, 16'd721);
    check("R3", "just under threshold shuts", 32'(bank_pwr_o), 32'hE);
    check("R4", "tie remap", 32'(remap_tgt_o), 32'hE5);
    run_epoch(2'd1, 16'h0000, 16'd720);
    check("R3", "at threshold restarts", 32'(bank_pwr_o), 32'hF);
    check("R11", "mig raised", 32'(migrate_req_o), 32'd1);
    check("R11", "remap held", 32'(remap_tgt_o), 32'hE5);
    run_epoch(2'd1, 16'h0000, 16'd790);
    check("R11", "no resize while pending", 32'(bank_pwr_o), 32'hF);
    check("R11", "mig still raised", 32'(migrate_req_o), 32'd1);
    pulse_ack();
    check("R11", "remap restored", 32'(remap_tgt_o), 32'hE4);

    // R7 stop-on-loss mode
    do_reset();
    run_epoch(2'd0, 16'h0000, 16'd800);
    run_epoch(2'd0, 16'h0000, 16'd790);
    check("R7", "shutdown before loss", 32'(bank_pwr_o), 32'hE);
    run_epoch(2'd0, 16'h0000, 16'd600);
    check("R7", "no restart", 32'(bank_pwr_o), 32'hE);
    check("R7", "no mig", 32'(migrate_req_o), 32'd0);
    run_epoch(2'd0, 16'h0000, 16'd790);
    check("R7", "shutdown stopped", 32'(bank_pwr_o), 32'hE);
    check("R7", "remap kept", 32'(remap_tgt_o), 32'hE5);

    finish_run();
  end
endmodule